// File: doc/BRIEF.md
# Receive/Transmit Queue Status Unit with DMA Ready Signalling

This block holds the byte queues that sit between a serial line engine and a host bus. The receive side stores each incoming character together with three error tags: parity, framing and break. The transmit side stores bytes that wait for the shifter. The block summarises queue state for a DMA engine through two active-low ready outputs, `rxrdy_n` and `txrdy_n`. Each of these follows one of two rule sets, chosen by a mode bit.

In mode 0, each ready output reports single-character status. In mode 1, each reports block status: the receive side is paced by a programmable trigger level or a timeout strobe, and the transmit side is paced by free space in its queue. The block also gives the host the following:
- a data-available flag,
- a trigger-reached flag,
- an error summary that covers every stored entry,
- the byte and tags at the head of the receive queue,
- a one-cycle overrun pulse for a write that was dropped.

Separate synchronous clear strobes empty each queue. The receiver, the shifter and the register decode live outside this block.

Top module: `rxtx_dma_fifo`

## Requirements
- R1: With `fifo_en`=1 each queue holds up to 16 entries. With `fifo_en`=0 each holds a single entry. `rx_count`/`tx_count` report the number of entries held.
- R2: A push into a full queue is dropped and the stored contents are kept. For the receive queue, `rx_overrun` is high for exactly the one cycle after the dropped push.
- R3: `trig_sel` codes 00, 01, 10 and 11 select receive trigger levels of 1, 4, 8 and 14. `rx_trig_hit` is 1 whenever `rx_count` is at or above the selected level.
- R4: With `dma_mode`=0, `rxrdy_n` is 0 exactly when the receive queue holds at least one entry.
- R5: With `dma_mode`=1, `rxrdy_n` goes to 0 in the cycle the count reaches the trigger level, or one cycle after an `rx_timeout` strobe while data is held. It then stays 0 until the receive queue is empty.
- R6: With `dma_mode`=0, `txrdy_n` is 0 only while the transmit queue is empty.
- R7: With `dma_mode`=1, `txrdy_n` is 0 while the transmit queue has a free entry and 1 only when it is full.
- R8: `rx_avail` is 1 exactly while the receive queue is non-empty.
- R9: `rx_fifo_err` is 1 while any stored receive entry carries a parity, framing or break tag. It clears once no remaining entry has one.
- R10: The queues are first-in first-out. `rx_head_*` and `tx_head_byte` show the oldest entry, with its tags.
- R11: `rx_clear`/`tx_clear` empty their own queue in one cycle. A clear overrides a push or pop in the same cycle. `rx_clear` also resets the error summary and the mode-1 hold, and it leaves the other queue untouched.
- R12: After reset both counts are 0, `rxrdy_n`=1, `txrdy_n`=0 and `rx_overrun`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| fifo_en | input | 1 | 1 = queues 16 deep, 0 = single entry |
| dma_mode | input | 1 | Ready signalling rule set (0 or 1) |
| trig_sel | input | 2 | Receive trigger level select |
| rx_clear | input | 1 | Empty receive queue |
| tx_clear | input | 1 | Empty transmit queue |
| rx_push | input | 1 | Receiver delivers a character |
| rx_byte | input | 8 | Received character |
| rx_par_err | input | 1 | Parity tag of the character |
| rx_frm_err | input | 1 | Framing tag of the character |
| rx_brk | input | 1 | Break tag of the character |
| rx_timeout | input | 1 | Receive timeout strobe |
| rx_pop | input | 1 | Host reads the head entry |
| tx_push | input | 1 | Host writes a byte |
| tx_byte | input | 8 | Byte to transmit |
| tx_pop | input | 1 | Shifter takes the head byte |
| rx_head_byte | output | 8 | Oldest received character |
| rx_head_par | output | 1 | Parity tag of the head entry |
| rx_head_frm | output | 1 | Framing tag of the head entry |
| rx_head_brk | output | 1 | Break tag of the head entry |
| rx_count | output | 5 | Receive entries held |
| rx_avail | output | 1 | Receive data available |
| rx_trig_hit | output | 1 | Count at or above the trigger level |
| rx_fifo_err | output | 1 | Some stored entry is tagged |
| rx_overrun | output | 1 | Pulse after a dropped receive push |
| rxrdy_n | output | 1 | Receive ready, active low |
| tx_head_byte | output | 8 | Oldest transmit byte |
| tx_count | output | 5 | Transmit entries held |
| txrdy_n | output | 1 | Transmit ready, active low |

## Verification
The bench drives pushes into full queues, and pushes and pops together at empty and full. A design that counted a dropped write would show a count of 17, and one that lost the pulse would never show `rx_overrun`.

It lets mode-1 receive queues drain below the trigger level, which a design without a hold would expose by raising `rxrdy_n` early. It also pops the last tagged entry while clean entries remain, which a design using a sticky error flag would miss. Finally, it issues clears that collide with a push or pop, and it toggles `fifo_en` while the queues hold data, so that capacity bugs show up as count mismatches.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic              brk;
    logic              frm;
    logic              par;
    logic [DATA_W-1:0] data;
  } rx_slot_t;

  // receive trigger level for a 2-bit select code
  function automatic int unsigned trig_level(input logic [1:0] sel);
    case (sel)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction

  function automatic logic slot_tagged(input rx_slot_t s);
    return s.brk | s.frm | s.par;
  endfunction
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          single,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cap;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign cap     = single ? CW'(1) : CW'(DEPTH);
  assign full    = count >= cap;
  assign push_ok = push && !full && !clr;
  assign pop_ok  = pop && (count != '0) && !clr;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_next(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/err_tally.sv
module err_tally #(
  parameter int CW = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  input  logic dec,
  output logic any_err
);
  logic [CW-1:0] tagged_cnt;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)                   tagged_cnt <= '0;
    else if (clr)              tagged_cnt <= '0;
    else if (inc && !dec)      tagged_cnt <= tagged_cnt + 1'b1;
    else if (dec && !inc)      tagged_cnt <= tagged_cnt - 1'b1;
  end

  assign any_err = tagged_cnt != '0;
endmodule

// File: rtl/rx_ready_ctl.sv
module rx_ready_ctl #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          mode1,
  input  logic          timeout,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] trig,
  output logic          trig_hit,
  output logic          held,
  output logic          rdy_n
);
  logic has_data;

  assign has_data = count != '0;
  assign trig_hit = count >= trig;

  // block-mode hold: set by trigger or timeout, dropped when empty
  always_ff @(posedge clk or posedge rst) begin
    if (rst)      held <= 1'b0;
    else if (clr) held <= 1'b0;
    else          held <= has_data && (held || trig_hit || timeout);
  end

  assign rdy_n = mode1 ? !(has_data && (held || trig_hit)) : !has_data;
endmodule

// File: rtl/rxtx_dma_fifo.sv
module rxtx_dma_fifo #(
  parameter int DEPTH = 16,
  localparam int DW   = rxq_pkg::DATA_W,
  localparam int SW   = DW + 3,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_en,
  input  logic          dma_mode,
  input  logic [1:0]    trig_sel,
  input  logic          rx_clear,
  input  logic          tx_clear,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_par_err,
  input  logic          rx_frm_err,
  input  logic          rx_brk,
  input  logic          rx_timeout,
  input  logic          rx_pop,
  input  logic          tx_push,
  input  logic [DW-1:0] tx_byte,
  input  logic          tx_pop,
  output logic [DW-1:0] rx_head_byte,
  output logic          rx_head_par,
  output logic          rx_head_frm,
  output logic          rx_head_brk,
  output logic [CW-1:0] rx_count,
  output logic          rx_avail,
  output logic          rx_trig_hit,
  output logic          rx_fifo_err,
  output logic          rx_overrun,
  output logic          rxrdy_n,
  output logic [DW-1:0] tx_head_byte,
  output logic [CW-1:0] tx_count,
  output logic          txrdy_n
);
  import rxq_pkg::*;

  rx_slot_t      rx_in, rx_head;
  logic [SW-1:0] rx_head_bits;
  logic          rx_full, tx_full;
  logic          rx_push_ok, rx_pop_ok, rx_held;
  logic [CW-1:0] rx_trig;

  assign rx_in = '{brk: rx_brk, frm: rx_frm_err, par: rx_par_err, data: rx_byte};

  byte_fifo #(.W(SW), .DEPTH(DEPTH)) rx_q_i (
    .clk(clk), .rst(rst), .clr(rx_clear), .single(!fifo_en),
    .push(rx_push), .pop(rx_pop), .din(rx_in),
    .dout(rx_head_bits), .count(rx_count), .full(rx_full)
  );

  byte_fifo #(.W(DW), .DEPTH(DEPTH)) tx_q_i (
    .clk(clk), .rst(rst), .clr(tx_clear), .single(!fifo_en),
    .push(tx_push), .pop(tx_pop), .din(tx_byte),
    .dout(tx_head_byte), .count(tx_count), .full(tx_full)
  );

  assign rx_head      = rx_slot_t'(rx_head_bits);
  assign rx_head_byte = rx_head.data;
  assign rx_head_par  = rx_head.par;
  assign rx_head_frm  = rx_head.frm;
  assign rx_head_brk  = rx_head.brk;

  // accepted transfers, named for the tally and the checker
  assign rx_push_ok = rx_push && !rx_full && !rx_clear;
  assign rx_pop_ok  = rx_pop && (rx_count != '0) && !rx_clear;

  err_tally #(.CW(CW)) tally_i (
    .clk(clk), .rst(rst), .clr(rx_clear),
    .inc(rx_push_ok && slot_tagged(rx_in)),
    .dec(rx_pop_ok && slot_tagged(rx_head)),
    .any_err(rx_fifo_err)
  );

  assign rx_trig = CW'(trig_level(trig_sel));

  rx_ready_ctl #(.CW(CW)) rdy_i (
    .clk(clk), .rst(rst), .clr(rx_clear), .mode1(dma_mode),
    .timeout(rx_timeout), .count(rx_count), .trig(rx_trig),
    .trig_hit(rx_trig_hit), .held(rx_held), .rdy_n(rxrdy_n)
  );

  always_ff @(posedge clk or posedge rst) begin
    if (rst) rx_overrun <= 1'b0;
    else     rx_overrun <= rx_push && rx_full && !rx_clear;
  end

  assign rx_avail = rx_count != '0;
  assign txrdy_n  = dma_mode ? tx_full : (tx_count != '0);
endmodule

// File: rtl/rxtx_dma_fifo_chk.sv
module rxtx_dma_fifo_chk #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          dma_mode,
  input logic          rx_clear,
  input logic          rx_push,
  input logic          rx_pop,
  input logic          rx_full,
  input logic          tx_full,
  input logic [CW-1:0] rx_count,
  input logic          rx_fifo_err,
  input logic          rx_overrun,
  input logic          rxrdy_n,
  input logic          txrdy_n
);
  // R1
  rx_cap_chk: assert property (@(posedge clk) disable iff (rst)
    rx_count <= CW'(DEPTH));

  // R2
  overrun_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_push && rx_full && !rx_clear |=> rx_overrun);

  // R2
  overrun_cause_chk: assert property (@(posedge clk) disable iff (rst)
    rx_overrun |-> $past(rx_full) && $past(rx_push));

  // R4
  mode0_rx_chk: assert property (@(posedge clk) disable iff (rst)
    !dma_mode && rx_count != '0 |-> !rxrdy_n);

  // R5
  mode1_hold_chk: assert property (@(posedge clk) disable iff (rst)
    dma_mode && !rxrdy_n && !rx_pop && !rx_clear |=> !dma_mode || !rxrdy_n);

  // R7
  mode1_tx_full_chk: assert property (@(posedge clk) disable iff (rst)
    dma_mode && tx_full |-> txrdy_n);

  // R9
  err_needs_data_chk: assert property (@(posedge clk) disable iff (rst)
    rx_fifo_err |-> rx_count != '0);

  // R11
  rx_clear_chk: assert property (@(posedge clk) disable iff (rst)
    rx_clear |=> rx_count == '0 && !rx_fifo_err);
endmodule

bind rxtx_dma_fifo rxtx_dma_fifo_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst(rst), .dma_mode(dma_mode), .rx_clear(rx_clear),
  .rx_push(rx_push), .rx_pop(rx_pop), .rx_full(rx_full), .tx_full(tx_full),
  .rx_count(rx_count), .rx_fifo_err(rx_fifo_err), .rx_overrun(rx_overrun),
  .rxrdy_n(rxrdy_n), .txrdy_n(txrdy_n)
);

// File: tb/rxtx_dma_fifo_tb_top.sv
`timescale 1ns/1ps
module rxtx_dma_fifo_tb_top;
  logic clk = 0, rst = 1;
  logic fifo_en = 1, dma_mode = 0;
  logic [1:0] trig_sel = 0;
  logic rx_clear = 0, tx_clear = 0, rx_push = 0, rx_pop = 0, rx_timeout = 0;
  logic rx_par_err = 0, rx_frm_err = 0, rx_brk = 0;
  logic [7:0] rx_byte = 0, tx_byte = 0;
  logic tx_push = 0, tx_pop = 0;
  logic [7:0] rx_head_byte, tx_head_byte;
  logic rx_head_par, rx_head_frm, rx_head_brk;
  logic [4:0] rx_count, tx_count;
  logic rx_avail, rx_trig_hit, rx_fifo_err, rx_overrun, rxrdy_n, txrdy_n;

  int ncmp = 0, nbad = 0;
  bit [10:0] rq[$];
  bit [7:0]  tq[$];
  bit m_held = 0, m_ovr = 0;

  always #10 clk = ~clk;

  rxtx_dma_fifo dut_i (.*);

  function automatic int m_trig(input logic [1:0] s);
    if (s == 2'd0) return 1;
    if (s == 2'd1) return 4;
    if (s == 2'd2) return 8;
    return 14;
  endfunction

  // reference model
  always @(posedge clk) begin
    int c, tc, cap;
    bit rpop, rpush, tpop, tpush;
    if (rst) begin
      rq.delete(); tq.delete(); m_held = 0; m_ovr = 0;
    end else begin
      c = rq.size(); tc = tq.size(); cap = fifo_en ? 16 : 1;
      m_held = (c != 0) && (m_held || c >= m_trig(trig_sel) || rx_timeout);
      m_ovr = 0;
      if (rx_clear) begin
        rq.delete(); m_held = 0;
      end else begin
        rpop = rx_pop && c > 0; rpush = rx_push && c < cap;
        m_ovr = rx_push && c >= cap;
        if (rpop) void'(rq.pop_front());
        if (rpush) rq.push_back({rx_brk, rx_frm_err, rx_par_err, rx_byte});
      end
      if (tx_clear) tq.delete();
      else begin
        tpop = tx_pop && tc > 0; tpush = tx_push && tc < cap;
        if (tpop) void'(tq.pop_front());
        if (tpush) tq.push_back(tx_byte);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    ncmp++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s t=%0t act=%0d exp=%0d", tag, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    int c = rq.size(), tc = tq.size(), cap = fifo_en ? 16 : 1;
    bit any = 0, e_rdy;
    foreach (rq[i]) if (rq[i][10:8] != 0) any = 1;
    chk(rx_count == c, "R1 rx_count", rx_count, c);
    chk(tx_count == tc, "R1 tx_count", tx_count, tc);
    chk(rx_overrun == m_ovr, "R2 rx_overrun", rx_overrun, m_ovr);
    chk(rx_trig_hit == (c >= m_trig(trig_sel)), "R3 rx_trig_hit", rx_trig_hit, c >= m_trig(trig_sel));
    if (dma_mode) begin
      e_rdy = !((c != 0) && (m_held || c >= m_trig(trig_sel)));
      chk(rxrdy_n == e_rdy, "R5 rxrdy_n", rxrdy_n, e_rdy);
      chk(txrdy_n == (tc >= cap), "R7 txrdy_n", txrdy_n, tc >= cap);
    end else begin
      chk(rxrdy_n == (c == 0), "R4 rxrdy_n", rxrdy_n, c == 0);
      chk(txrdy_n == (tc != 0), "R6 txrdy_n", txrdy_n, tc != 0);
    end
    chk(rx_avail == (c != 0), "R8 rx_avail", rx_avail, c != 0);
    chk(rx_fifo_err == any, "R9 rx_fifo_err", rx_fifo_err, any);
    if (c > 0)
      chk({rx_head_brk, rx_head_frm, rx_head_par, rx_head_byte} == rq[0],
          "R10 rx head", {rx_head_brk, rx_head_frm, rx_head_par, rx_head_byte}, rq[0]);
    if (tc > 0) chk(tx_head_byte == tq[0], "R10 tx head", tx_head_byte, tq[0]);
  endtask

  always @(negedge clk) if (!rst) compare_all();

  // one phase of random traffic; clears are rare so R11 collisions occur
  task automatic phase(input int n, input bit en, input bit md, input logic [1:0] ts,
                       input int p_push, input int p_pop);
    fifo_en = en; dma_mode = md; trig_sel = ts;
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      rx_push    = ($urandom_range(99) < p_push);
      rx_pop     = ($urandom_range(99) < p_pop);
      tx_push    = ($urandom_range(99) < p_push);
      tx_pop     = ($urandom_range(99) < p_pop);
      rx_byte    = 8'($urandom); tx_byte = 8'($urandom);
      rx_par_err = ($urandom_range(9) == 0);
      rx_frm_err = ($urandom_range(9) == 0);
      rx_brk     = ($urandom_range(14) == 0);
      rx_timeout = ($urandom_range(29) == 0);
      rx_clear   = ($urandom_range(149) == 0);
      tx_clear   = ($urandom_range(149) == 0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R12 reset state
    chk(rx_count == 0 && tx_count == 0, "R12 counts", rx_count, 0);
    chk(rxrdy_n == 1, "R12 rxrdy_n", rxrdy_n, 1);
    chk(txrdy_n == 0, "R12 txrdy_n", txrdy_n, 0);
    chk(rx_overrun == 0, "R12 rx_overrun", rx_overrun, 0);
    for (int t = 0; t < 4; t++) begin
      phase(300, 1, 0, 2'(t), 80, 20);  // fill past full: R1 R2 R4 R6
      phase(300, 1, 0, 2'(t), 20, 80);  // drain
      phase(300, 1, 1, 2'(t), 60, 15);  // R5 R7 hold and full
      phase(300, 1, 1, 2'(t), 15, 60);  // drain below trigger: R5 hold
      phase(200, 0, t[0], 2'(t), 50, 40); // single entry: R1
      phase(200, 1, 1, 2'(t), 45, 45);
    end
    @(posedge clk); #1;
    rx_push = 0; tx_push = 0; rx_pop = 0; tx_pop = 0; rx_clear = 1; tx_clear = 1;
    @(posedge clk); #1; rx_clear = 0; tx_clear = 0;
    @(negedge clk);
    chk(rx_count == 0 && !rx_fifo_err, "R11 final clear", rx_count, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  end

  initial begin
    #4000000;
    ncmp++; nbad++;
    $display("FAIL watchdog act=1 exp=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  end
endmodule